// File: doc/BRIEF.md
# Storage Key Reference/Change Recorder

This block keeps one 7-bit storage key for every 4 KiB page of absolute memory and updates the key's usage bits each time the address translation logic builds a new translation. A translation request brings the absolute address, the kind of access (data load, data store or instruction fetch) and the permission set that translation has granted so far. The block reads the page's key, sets the reference bit (and the change bit on a store), writes the key back only if its value moved, and returns a possibly narrowed permission set. On a load or fetch to a page whose change bit is still clear, write permission is withheld, so a later store to that page must fault again and get its change recorded.

Requests enter on a valid/ready port. `req_ready` is high only while the block is idle. A request is taken on a cycle where `req_valid` and `req_ready` are both high, and the request fields must be stable in that cycle only. The result comes back as a one-cycle `rsp_valid` strobe with `rsp_perm`. The result port has no back-pressure: the consumer must take the strobe when it appears. A global enable turns all key activity off. A direct port lets maintenance logic write or read any key. It always wins the array over the update path, which stalls, or re-reads the key if it was interrupted between read and write.

Top module: `skey_rc_updater`

## Requirements
- R1: If `keys_en` is low in the cycle a request is taken, the block makes no key read or write, returns `rsp_perm` equal to `req_perm`, and raises `rsp_valid` exactly 1 cycle after acceptance.
- R2: Access kinds are coded 0 = data load, 1 = data store, 2 = instruction fetch, and 3 is handled as a data load. Permission bits are bit 0 = read, bit 1 = write, bit 2 = execute. For kinds 0, 2 and 3, if the key's change bit is clear, `rsp_perm` is `req_perm` with bit 1 cleared. In every other case `rsp_perm` equals `req_perm`.
- R3: A store (kind 1) leaves the page's change bit (key bit 0) set.
- R4: Every enabled request leaves the page's reference bit (key bit 1) set. Key bits 6:2 (access key in 6:3, fetch-protect in 2) keep their old values.
- R5: The key is written back only when the updated value differs from the stored value. A key that already holds the needed bits keeps its value.
- R6: The key index is `req_addr >> 12`. The low 12 address bits have no effect, and no other page's key changes.
- R7: `req_ready` is high only when idle. With the direct port quiet, `rsp_valid` is high for exactly one cycle, 3 cycles after acceptance.
- R8: After reset every key is zero, `req_ready` is high and `rsp_valid` is low.
- R9: When `dir_en` is high with `dir_we` high, `dir_wkey` is written to key `dir_idx`. When `dir_en` is high with `dir_we` low, `dir_rvalid` is high in the next cycle with that key on `dir_rkey`. A direct access takes priority over an update in progress: the update stalls one cycle before its read, or re-reads the key if the direct access fell between its read and its write, and its result then includes the direct write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| keys_en | input | 1 | Global enable for key updates, sampled at acceptance |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Block idle and able to take a request |
| req_addr | input | ADDR_W | Absolute address of the access |
| req_kind | input | 2 | Access kind (0 load, 1 store, 2 fetch, 3 as load) |
| req_perm | input | 3 | Incoming permissions {exec, write, read} |
| rsp_valid | output | 1 | One-cycle completion strobe |
| rsp_perm | output | 3 | Adjusted permissions, valid with rsp_valid |
| dir_en | input | 1 | Direct key access this cycle |
| dir_we | input | 1 | Direct access is a write |
| dir_idx | input | ADDR_W-12 | Page index for direct access |
| dir_wkey | input | 7 | Key value for a direct write |
| dir_rvalid | output | 1 | Direct read data valid |
| dir_rkey | output | 7 | Key returned by a direct read |

## Verification
An update in progress and a direct key access can land in the same cycle. The bench provokes this on purpose. It issues a direct read to another page in the cycle where the update would read the array, and expects the update to finish one cycle later with correct results and the direct read to return that page's key. It then issues a direct write to the same page in the cycle between the update's read and its write. It expects the update to finish two cycles late, with both its key result and its permission result computed from the directly written value.

// File: rtl/skey_pkg.sv
package skey_pkg;

  localparam int KEY_W  = 7;
  localparam int PERM_W = 3;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_kind_e;

  typedef struct packed {
    logic [3:0] acc;
    logic       fp;
    logic       refd;
    logic       chgd;
  } skey_t;

  typedef struct packed {
    logic x;
    logic w;
    logic r;
  } perm_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_EV   = 2'd2,
    ST_DONE = 2'd3
  } upd_state_e;

endpackage

// File: rtl/skey_array.sv
module skey_array
  import skey_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output skey_t            rd_key,
  input  logic             we,
  input  logic [IDX_W-1:0] wr_idx,
  input  skey_t            wr_key
);

  localparam int NUM_KEYS = 1 << IDX_W;

  skey_t cells [NUM_KEYS];

  for (genvar g = 0; g < NUM_KEYS; g++) begin : g_cell
    skey_t cell_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cell_q <= '0;
      end else if (we && (wr_idx == IDX_W'(g))) begin
        cell_q <= wr_key;
      end
    end
    assign cells[g] = cell_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_key <= '0;
    end else if (rd_en) begin
      rd_key <= cells[rd_idx];
    end
  end

endmodule

// File: rtl/skey_rule.sv
module skey_rule
  import skey_pkg::*;
(
  input  acc_kind_e kind,
  input  skey_t     old_key,
  input  perm_t     perm_in,
  output skey_t     new_key,
  output perm_t     perm_out,
  output logic      changed
);

  always_comb begin
    new_key      = old_key;
    new_key.refd = 1'b1;
    if (kind == ACC_STORE) begin
      new_key.chgd = 1'b1;
    end
    perm_out = perm_in;
    // Non-store with clean page: keep write off so the first store faults.
    if ((kind != ACC_STORE) && !old_key.chgd) begin
      perm_out.w = 1'b0;
    end
    changed = (new_key != old_key);
  end

endmodule

// File: rtl/skey_update_fsm.sv
module skey_update_fsm
  import skey_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             keys_en,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [IDX_W-1:0] req_idx,
  input  acc_kind_e        req_kind,
  input  perm_t            req_perm,
  input  logic             dir_busy,
  output logic             ram_rd_en,
  output logic [IDX_W-1:0] ram_idx,
  input  skey_t            ram_rd_key,
  output logic             ram_we,
  output skey_t            ram_wr_key,
  output logic             rsp_valid,
  output perm_t            rsp_perm
);

  upd_state_e       state_q;
  logic [IDX_W-1:0] idx_q;
  acc_kind_e        kind_q;
  perm_t            perm_q;
  logic             en_q;
  perm_t            rsp_perm_q;

  skey_t new_key;
  perm_t adj_perm;
  logic  key_changed;

  skey_rule u_rule (
    .kind     (kind_q),
    .old_key  (ram_rd_key),
    .perm_in  (perm_q),
    .new_key  (new_key),
    .perm_out (adj_perm),
    .changed  (key_changed)
  );

  assign req_ready  = (state_q == ST_IDLE);
  assign rsp_valid  = (state_q == ST_DONE);
  assign rsp_perm   = rsp_perm_q;
  assign ram_idx    = idx_q;
  assign ram_rd_en  = (state_q == ST_RD) && !dir_busy;
  assign ram_we     = (state_q == ST_EV) && !dir_busy && key_changed;
  assign ram_wr_key = new_key;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      idx_q      <= '0;
      kind_q     <= ACC_LOAD;
      perm_q     <= '0;
      en_q       <= 1'b0;
      rsp_perm_q <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            idx_q  <= req_idx;
            kind_q <= req_kind;
            perm_q <= req_perm;
            en_q   <= keys_en;
            if (keys_en) begin
              state_q <= ST_RD;
            end else begin
              rsp_perm_q <= req_perm;
              state_q    <= ST_DONE;
            end
          end
        end
        ST_RD: begin
          if (!dir_busy) begin
            state_q <= ST_EV;
          end
        end
        ST_EV: begin
          if (dir_busy) begin
            state_q <= ST_RD;
          end else begin
            rsp_perm_q <= adj_perm;
            state_q    <= ST_DONE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  p_no_access_disabled_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q != ST_IDLE) && !en_q) |-> (!ram_rd_en && !ram_we));

  p_perm_narrow_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ((rsp_perm & ~perm_q) == '0));

  p_store_sets_chg_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && (kind_q == ACC_STORE)) |-> ram_wr_key.chgd);

  p_ref_written_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (ram_wr_key.refd && (ram_wr_key.acc == ram_rd_key.acc)));

  p_wb_on_change_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (ram_wr_key != ram_rd_key));

  p_strobe_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

endmodule

// File: rtl/skey_rc_updater.sv
module skey_rc_updater
  import skey_pkg::*;
#(
  parameter  int ADDR_W    = 20,
  parameter  int PAGE_BITS = 12,
  localparam int IDX_W     = ADDR_W - PAGE_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              keys_en,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_kind,
  input  logic [2:0]        req_perm,
  output logic              rsp_valid,
  output logic [2:0]        rsp_perm,
  input  logic              dir_en,
  input  logic              dir_we,
  input  logic [IDX_W-1:0]  dir_idx,
  input  logic [6:0]        dir_wkey,
  output logic              dir_rvalid,
  output logic [6:0]        dir_rkey
);

  logic             unused_offset;
  logic [IDX_W-1:0] page_idx;
  logic             fsm_rd, fsm_we;
  logic [IDX_W-1:0] fsm_idx;
  skey_t            fsm_wkey;
  skey_t            arr_rkey;
  perm_t            fsm_rsp_perm;
  logic             arr_rd, arr_we;
  logic [IDX_W-1:0] arr_ridx, arr_widx;
  skey_t            arr_wkey;
  logic             dir_rvalid_q;

  assign page_idx      = req_addr[ADDR_W-1:PAGE_BITS];
  assign unused_offset = ^req_addr[PAGE_BITS-1:0];

  skey_update_fsm #(.IDX_W(IDX_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .keys_en    (keys_en),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_idx    (page_idx),
    .req_kind   (acc_kind_e'(req_kind)),
    .req_perm   (perm_t'(req_perm)),
    .dir_busy   (dir_en),
    .ram_rd_en  (fsm_rd),
    .ram_idx    (fsm_idx),
    .ram_rd_key (arr_rkey),
    .ram_we     (fsm_we),
    .ram_wr_key (fsm_wkey),
    .rsp_valid  (rsp_valid),
    .rsp_perm   (fsm_rsp_perm)
  );

  // Direct port owns the array whenever it is active.
  assign arr_rd   = (dir_en && !dir_we) || fsm_rd;
  assign arr_ridx = dir_en ? dir_idx : fsm_idx;
  assign arr_we   = (dir_en && dir_we) || fsm_we;
  assign arr_widx = dir_en ? dir_idx : fsm_idx;
  assign arr_wkey = dir_en ? skey_t'(dir_wkey) : fsm_wkey;

  skey_array #(.IDX_W(IDX_W)) u_array (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_en  (arr_rd),
    .rd_idx (arr_ridx),
    .rd_key (arr_rkey),
    .we     (arr_we),
    .wr_idx (arr_widx),
    .wr_key (arr_wkey)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dir_rvalid_q <= 1'b0;
    else        dir_rvalid_q <= dir_en && !dir_we;
  end

  assign dir_rvalid = dir_rvalid_q;
  assign dir_rkey   = arr_rkey;
  assign rsp_perm   = fsm_rsp_perm;

  p_dir_priority_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dir_en |-> (!fsm_rd && !fsm_we));

  p_ready_not_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

endmodule

// File: tb/tb_skey_rc_updater.sv
module tb_skey_rc_updater;

  localparam int ADDR_W = 16;
  localparam int IDX_W  = 4;
  localparam int NPG    = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              keys_en = 1'b1;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [1:0]        req_kind = '0;
  logic [2:0]        req_perm = '0;
  logic              rsp_valid;
  logic [2:0]        rsp_perm;
  logic              dir_en = 1'b0;
  logic              dir_we = 1'b0;
  logic [IDX_W-1:0]  dir_idx = '0;
  logic [6:0]        dir_wkey = '0;
  logic              dir_rvalid;
  logic [6:0]        dir_rkey;

  int n_chk = 0;
  int n_fail = 0;
  logic [6:0] mk [NPG];

  always #2 clk = ~clk;

  skey_rc_updater #(.ADDR_W(ADDR_W), .PAGE_BITS(12)) dut (
    .clk(clk), .rst_n(rst_n), .keys_en(keys_en),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_kind(req_kind), .req_perm(req_perm),
    .rsp_valid(rsp_valid), .rsp_perm(rsp_perm),
    .dir_en(dir_en), .dir_we(dir_we), .dir_idx(dir_idx), .dir_wkey(dir_wkey),
    .dir_rvalid(dir_rvalid), .dir_rkey(dir_rkey)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic dwrite(input int pg, input logic [6:0] k);
    @(negedge clk);
    dir_en = 1'b1; dir_we = 1'b1; dir_idx = IDX_W'(pg); dir_wkey = k;
    @(negedge clk);
    dir_en = 1'b0; dir_we = 1'b0;
    mk[pg] = k;
  endtask

  task automatic dread(input int pg, output logic [6:0] k, output logic v);
    @(negedge clk);
    dir_en = 1'b1; dir_we = 1'b0; dir_idx = IDX_W'(pg);
    @(negedge clk);
    v = dir_rvalid; k = dir_rkey;
    dir_en = 1'b0;
  endtask

  task automatic check_key(input int pg, input string req);
    logic [6:0] k;
    logic v;
    dread(pg, k, v);
    chk(v == 1'b1, "R9", "direct read valid", int'(v), 1);
    chk(k == mk[pg], req, $sformatf("key of page %0d", pg), int'(k), int'(mk[pg]));
  endtask

  // Accept a request at a posedge; lat counts negedges until rsp_valid.
  task automatic do_update(input logic [ADDR_W-1:0] a, input logic [1:0] kd,
                           input logic [2:0] pm, output logic [2:0] got,
                           output int lat);
    @(negedge clk);
    req_addr = a; req_kind = kd; req_perm = pm; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!rsp_valid && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    got = rsp_perm;
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R7", "strobe one cycle", int'(rsp_valid), 0);
  endtask

  function automatic logic [2:0] exp_perm(input logic [1:0] kd, input logic [2:0] pm,
                                          input logic [6:0] k);
    if (kd != 2'd1 && !k[0]) return pm & 3'b101;
    return pm;
  endfunction

  function automatic logic [6:0] exp_key(input logic [1:0] kd, input logic [6:0] k);
    return k | 7'b0000010 | ((kd == 2'd1) ? 7'b0000001 : 7'b0);
  endfunction

  initial begin
    #(200000 * 4);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [2:0] got;
    int lat;
    logic [6:0] k0;
    logic v0;

    for (int i = 0; i < NPG; i++) mk[i] = '0;
    repeat (3) @(negedge clk);
    // R8: reset state
    chk(req_ready == 1'b1, "R8", "ready in reset", int'(req_ready), 1);
    chk(rsp_valid == 1'b0, "R8", "rsp_valid in reset", int'(rsp_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R8", "ready after reset", int'(req_ready), 1);
    for (int pg = 0; pg < NPG; pg++) check_key(pg, "R8");

    // Enabled sweep: every page, R/C state, kind and permission set.
    for (int pg = 0; pg < NPG; pg++) begin
      for (int rc = 0; rc < 4; rc++) begin
        for (int kd = 0; kd < 4; kd++) begin
          for (int pm = 0; pm < 8; pm++) begin
            logic [6:0] ik;
            logic [6:0] ek;
            logic [2:0] ep;
            logic [11:0] off;
            ik = {4'(pg + pm), 1'(kd), 2'(rc)};
            dwrite(pg, ik);
            off = 12'((pg * 291 + pm * 517 + kd * 1237) & 32'hFFF);
            ep = exp_perm(2'(kd), 3'(pm), ik);
            ek = exp_key(2'(kd), ik);
            do_update({4'(pg), off}, 2'(kd), 3'(pm), got, lat);
            mk[pg] = ek;
            chk(got == ep, "R2", $sformatf("perm pg%0d rc%0d kind%0d", pg, rc, kd),
                int'(got), int'(ep));
            chk(lat == 3, "R7", "update latency", lat, 3);
            if (kd == 1)
              check_key(pg, "R3");
            else if (rc == 3)
              check_key(pg, "R5");
            else
              check_key(pg, "R4");
            check_key(pg ^ 1, "R6");
          end
        end
      end
    end

    // R1: disabled, keys untouched and permissions pass through.
    keys_en = 1'b0;
    for (int pg = 0; pg < NPG; pg += 3) begin
      for (int kd = 0; kd < 4; kd++) begin
        dwrite(pg, 7'(pg * 8));
        do_update({4'(pg), 12'h123}, 2'(kd), 3'b011, got, lat);
        chk(got == 3'b011, "R1", "perm when disabled", int'(got), 3);
        chk(lat == 1, "R1", "latency when disabled", lat, 1);
        check_key(pg, "R1");
      end
    end
    keys_en = 1'b1;

    // R9: direct read in the update's read cycle (different page).
    dwrite(3, 7'b1010000);
    dwrite(5, 7'b0110011);
    @(negedge clk);
    req_addr = {4'd3, 12'hFFF}; req_kind = 2'd1; req_perm = 3'b111; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    dir_en = 1'b1; dir_we = 1'b0; dir_idx = 4'd5;
    @(negedge clk);
    v0 = dir_rvalid; k0 = dir_rkey;
    dir_en = 1'b0;
    chk(v0 == 1'b1 && k0 == 7'b0110011, "R9", "direct read during update",
        int'(k0), 'h33);
    lat = 2;
    while (!rsp_valid && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    chk(lat == 4, "R9", "latency with read stall", lat, 4);
    chk(rsp_perm == 3'b111, "R9", "perm with read stall", int'(rsp_perm), 7);
    mk[3] = 7'b1010011;
    check_key(3, "R9");

    // R9: direct write to same page between update's read and write.
    dwrite(7, 7'b0000011);
    @(negedge clk);
    req_addr = {4'd7, 12'h040}; req_kind = 2'd0; req_perm = 3'b111; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    dir_en = 1'b1; dir_we = 1'b1; dir_idx = 4'd7; dir_wkey = 7'b1100100;
    @(negedge clk);
    dir_en = 1'b0; dir_we = 1'b0;
    lat = 3;
    while (!rsp_valid && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    chk(lat == 5, "R9", "latency with re-read", lat, 5);
    chk(rsp_perm == 3'b101, "R9", "perm uses directly written key", int'(rsp_perm), 5);
    mk[7] = 7'b1100110;
    check_key(7, "R9");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule